// File: doc/BRIEF.md
# Configurable Serial Character Transmitter with Break

This block turns bytes offered on a valid/ready input into asynchronous serial characters on a single transmit line. Bit timing comes from an external strobe that pulses sixteen times per bit period; the block counts those strobes and holds each bit for exactly sixteen of them. A one-deep holding register decouples the producer from the shifter, so a second byte can be accepted while the first is still on the line and the two characters go out back to back.

Per-character options are taken from static configuration inputs: seven or eight data bits, optional parity of either sense, one or two stop bits, and a test mode that sends the wrong parity on purpose. The line can be inverted as a whole. A break request replaces characters with a continuous low level, starting at the next character boundary. When flow control is in use, a new character is started only while the active-low clear-to-send input is low, and a character already started always finishes. A completion flag reports when the line is idle with nothing waiting.

Options are sampled when a character starts, so changing them during a character affects only the next one.

Top module: `uart_serializer_tx`

## Requirements
- R1: After reset the transmit line is high (with inversion off), `in_ready` is 1 and `tx_done` is 1.
- R2: A character is a single low start bit, then the data bits least significant first, each bit lasting 16 `tick16` pulses; `cfg_eight_bits` = 1 sends 8 data bits, 0 sends the low 7 bits of `in_data`.
- R3: With `cfg_parity_en` = 1 one parity bit follows the data; with `cfg_parity_odd` = 0 the data bits plus parity bit hold an even count of ones, with 1 an odd count. With `cfg_parity_en` = 0 no parity bit is sent.
- R4: With `cfg_force_bad_parity` = 1 the parity bit sent is the complement of the value R3 gives.
- R5: The character ends with one high stop bit when `cfg_two_stop` = 0, two when it is 1.
- R6: While `cfg_break` is 1 the line is held low, starting no earlier than the end of any character in progress; after `cfg_break` returns to 0 the line is high for one stop length (per `cfg_two_stop`) before any new character starts.
- R7: `cfg_invert` = 1 inverts every level on `tx_line`, including the idle level.
- R8: With `cfg_ignore_cts` = 0 a character starts only while `cts_n` is 0; a change of `cts_n` during a character does not cut it short. With `cfg_ignore_cts` = 1 `cts_n` has no effect.
- R9: `tx_done` is 1 only when no character or break is being sent and no byte is waiting in the holding register.
- R10: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1; `in_ready` is 0 on the following cycle and returns to 1 once the byte has moved into the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Strobe at 16 times the bit rate, one clock wide |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Holding register empty, byte will be taken |
| cfg_eight_bits | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_parity_en | input | 1 | Send a parity bit |
| cfg_parity_odd | input | 1 | 0: even parity, 1: odd parity |
| cfg_two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| cfg_force_bad_parity | input | 1 | Send the complemented parity |
| cfg_invert | input | 1 | Invert the transmit line |
| cfg_break | input | 1 | Hold the line low at the next boundary |
| cfg_ignore_cts | input | 1 | 1: start regardless of `cts_n` |
| cts_n | input | 1 | Active-low clear-to-send |
| tx_line | output | 1 | Serial output, registered |
| tx_done | output | 1 | Idle with nothing pending, registered |

## Verification
A wrong internal state shows up on `tx_line` within one bit period: a miscounted bit index shifts every later bit of the character and moves the stop bit, a wrong parity latch flips the bit sampled just before the stop bit, and a stuck sequencer leaves the line at a constant level that the bench reads as a missing start edge or a bad stop bit. Holding-register errors appear within one clock as `in_ready` failing to drop after an accepted byte, and as `tx_done` being 1 while a byte waits for `cts_n`. Break and flow-control misbehaviour is visible as a start edge arriving while it must not, or a high gap shorter than one stop length after a break.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_BREAK,
    ST_BRK_END
  } tx_state_e;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          take,
  output logic          hold_full,
  output logic [DW-1:0] hold_data
);
  logic accept;
  assign accept = in_valid && !hold_full;

  always_ff @(posedge clk) begin
    if (rst)         hold_full <= 1'b0;
    else if (accept) hold_full <= 1'b1;
    else if (take)   hold_full <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (accept) hold_data <= in_data;
  end
endmodule

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  output logic bit_end
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart)    cnt <= '0;
    else if (tick)         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign bit_end = tick && !restart && (cnt == LAST);
endmodule

// File: rtl/uart_tx_sequencer.sv
module uart_tx_sequencer
  import uart_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          bit_end,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  input  logic          cfg_eight_bits,
  input  logic          cfg_parity_en,
  input  logic          cfg_parity_odd,
  input  logic          cfg_two_stop,
  input  logic          cfg_force_bad_parity,
  input  logic          cfg_break,
  input  logic          cfg_ignore_cts,
  input  logic          cts_n,
  output logic          take,
  output logic          restart,
  output logic          line_bit,
  output tx_state_e     state
);
  localparam int IW = $clog2(DW);
  localparam logic [IW-1:0] LAST_FULL  = IW'(DW - 1);
  localparam logic [IW-1:0] LAST_SHORT = IW'(DW - 2);

  logic [DW-1:0] shreg;
  logic [IW-1:0] bit_idx;
  logic          par_bit, f_eight, f_par, f_two, second_stop;
  logic          may_start;
  logic [DW-1:0] masked;

  assign may_start = hold_full && (cfg_ignore_cts || !cts_n);
  assign masked    = cfg_eight_bits ? hold_data : {1'b0, hold_data[DW-2:0]};

  always_comb begin
    take    = 1'b0;
    restart = 1'b0;
    if (state == ST_IDLE && tick) begin
      if (cfg_break) begin
        restart = 1'b1;
      end else if (may_start) begin
        restart = 1'b1;
        take    = 1'b1;
      end
    end
  end

  always_comb begin
    case (state)
      ST_START, ST_BREAK: line_bit = 1'b0;
      ST_DATA:            line_bit = shreg[0];
      ST_PARITY:          line_bit = par_bit;
      default:            line_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      shreg       <= '0;
      bit_idx     <= '0;
      par_bit     <= 1'b0;
      f_eight     <= 1'b1;
      f_par       <= 1'b0;
      f_two       <= 1'b0;
      second_stop <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (restart && !take) begin
            state       <= ST_BREAK;
          end else if (take) begin
            state       <= ST_START;
            shreg       <= masked;
            par_bit     <= (^masked) ^ cfg_parity_odd ^ cfg_force_bad_parity;
            f_eight     <= cfg_eight_bits;
            f_par       <= cfg_parity_en;
            f_two       <= cfg_two_stop;
          end
        end
        ST_START: if (bit_end) begin
          state   <= ST_DATA;
          bit_idx <= '0;
        end
        ST_DATA: if (bit_end) begin
          shreg   <= shreg >> 1;
          bit_idx <= bit_idx + 1'b1;
          if (bit_idx == (f_eight ? LAST_FULL : LAST_SHORT)) begin
            state       <= f_par ? ST_PARITY : ST_STOP;
            second_stop <= 1'b0;
          end
        end
        ST_PARITY: if (bit_end) begin
          state       <= ST_STOP;
          second_stop <= 1'b0;
        end
        ST_STOP, ST_BRK_END: if (bit_end) begin
          if (f_two && !second_stop) second_stop <= 1'b1;
          else                       state       <= ST_IDLE;
        end
        ST_BREAK: if (bit_end && !cfg_break) begin
          state       <= ST_BRK_END;
          f_two       <= cfg_two_stop;
          second_stop <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_serializer_tx.sv
module uart_serializer_tx
  import uart_tx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick16,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          cfg_eight_bits,
  input  logic          cfg_parity_en,
  input  logic          cfg_parity_odd,
  input  logic          cfg_two_stop,
  input  logic          cfg_force_bad_parity,
  input  logic          cfg_invert,
  input  logic          cfg_break,
  input  logic          cfg_ignore_cts,
  input  logic          cts_n,
  output logic          tx_line,
  output logic          tx_done
);
  logic          hold_full, take, restart, bit_end, line_bit;
  logic [DW-1:0] hold_data;
  tx_state_e     seq_state;

  uart_tx_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .take(take), .hold_full(hold_full), .hold_data(hold_data)
  );

  uart_tx_bit_timer #(.OVS(OVS)) u_timer (
    .clk(clk), .rst(rst), .tick(tick16), .restart(restart), .bit_end(bit_end)
  );

  uart_tx_sequencer #(.DW(DW)) u_seq (
    .clk(clk), .rst(rst), .tick(tick16), .bit_end(bit_end),
    .hold_full(hold_full), .hold_data(hold_data),
    .cfg_eight_bits(cfg_eight_bits), .cfg_parity_en(cfg_parity_en),
    .cfg_parity_odd(cfg_parity_odd), .cfg_two_stop(cfg_two_stop),
    .cfg_force_bad_parity(cfg_force_bad_parity), .cfg_break(cfg_break),
    .cfg_ignore_cts(cfg_ignore_cts), .cts_n(cts_n),
    .take(take), .restart(restart), .line_bit(line_bit), .state(seq_state)
  );

  assign in_ready = !hold_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_line <= !cfg_invert;
      tx_done <= 1'b1;
    end else begin
      tx_line <= line_bit ^ cfg_invert;
      tx_done <= (seq_state == ST_IDLE) && !hold_full;
    end
  end
endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker
  import uart_tx_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      in_valid,
  input logic      in_ready,
  input logic      cts_n,
  input logic      cfg_ignore_cts,
  input logic      cfg_break,
  input logic      cfg_invert,
  input logic      tx_line,
  input logic      tx_done,
  input tx_state_e st
);
  assert_accept_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  assert_start_needs_cts_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START && $past(st) == ST_IDLE) |-> $past(cfg_ignore_cts || !cts_n));

  assert_no_start_in_break_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START && $past(st) == ST_IDLE) |-> !$past(cfg_break));

  assert_break_from_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BREAK && $past(st) != ST_BREAK) |-> $past(st) == ST_IDLE);

  assert_done_line_idle_R9: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> (tx_line == !$past(cfg_invert)));
endmodule

bind uart_serializer_tx uart_tx_checker u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .cts_n(cts_n), .cfg_ignore_cts(cfg_ignore_cts), .cfg_break(cfg_break),
  .cfg_invert(cfg_invert), .tx_line(tx_line), .tx_done(tx_done), .st(seq_state)
);

// File: tb/uart_serializer_tx_test.sv
module uart_serializer_tx_test;
  localparam int BITCLK = 64;   // 16 ticks x 4 clocks
  localparam int HALF   = 32;
  localparam int NV     = 8;
  // {data[7:0], eight, parity_en, odd, two_stop, force, invert}
  localparam logic [13:0] VEC [NV] = '{
    {8'hA5, 6'b100000},
    {8'h3C, 6'b110000},
    {8'h3D, 6'b111000},
    {8'h81, 6'b010100},
    {8'h5A, 6'b110010},
    {8'hF0, 6'b100101},
    {8'h01, 6'b000000},
    {8'hFF, 6'b111111}
  };

  logic clk = 1'b0, rst = 1'b1, tick16 = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, tx_line, tx_done;
  logic c_eight = 1'b1, c_pe = 1'b0, c_odd = 1'b0, c_two = 1'b0, c_frc = 1'b0;
  logic c_inv = 1'b0, c_brk = 1'b0, c_ign = 1'b1, cts_n = 1'b1;
  int checks = 0, errors = 0;
  logic [1:0] tdiv = '0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  uart_serializer_tx uut (
    .clk(clk), .rst(rst), .tick16(tick16), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .cfg_eight_bits(c_eight), .cfg_parity_en(c_pe),
    .cfg_parity_odd(c_odd), .cfg_two_stop(c_two), .cfg_force_bad_parity(c_frc),
    .cfg_invert(c_inv), .cfg_break(c_brk), .cfg_ignore_cts(c_ign), .cts_n(cts_n),
    .tx_line(tx_line), .tx_done(tx_done)
  );

  task automatic check(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_start();
    while ((tx_line ^ c_inv) != 1'b0) @(negedge clk);
  endtask

  // Samples one character from its start edge and checks it against R2..R5.
  task automatic rx_body(input logic [7:0] d, input logic check_done);
    logic [7:0] got, expd;
    logic st0, pbit, s1, s2;
    int nb;
    nb   = c_eight ? 8 : 7;
    expd = c_eight ? d : {1'b0, d[6:0]};
    got  = '0;
    pbit = 1'b0;
    repeat (HALF) @(negedge clk);
    st0 = tx_line ^ c_inv;
    for (int i = 0; i < nb; i++) begin
      repeat (BITCLK) @(negedge clk);
      got[i] = tx_line ^ c_inv;
    end
    if (c_pe) begin
      repeat (BITCLK) @(negedge clk);
      pbit = tx_line ^ c_inv;
    end
    repeat (BITCLK) @(negedge clk);
    s1 = tx_line ^ c_inv;
    s2 = 1'b1;
    if (c_two) begin
      repeat (BITCLK) @(negedge clk);
      s2 = tx_line ^ c_inv;
    end
    check(st0 == 1'b0, "R2 start bit", st0, 0);
    check(got == expd, "R2 data bits", got, expd);
    if (c_pe)
      check(pbit == ((^expd) ^ c_odd ^ c_frc), "R3 R4 parity bit", pbit, (^expd) ^ c_odd ^ c_frc);
    check({s1, s2} == 2'b11, "R5 stop bits", {s1, s2}, 3);
    if (check_done) begin
      repeat (40) @(negedge clk);
      check(tx_done == 1'b1, "R9 done after frame", tx_done, 1);
    end
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic check_done);
    wait_start();
    rx_body(d, check_done);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi_len;
    logic all_low;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(tx_line == 1'b1, "R1 line idle", tx_line, 1);
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);
    check(tx_done == 1'b1, "R1 done", tx_done, 1);

    // Table of frame formats: R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      {in_data, c_eight, c_pe, c_odd, c_two, c_frc, c_inv} = {VEC[v][13:6], VEC[v][5:0]};
      repeat (2) @(negedge clk);
      check(tx_line == !c_inv, "R7 idle level", tx_line, !c_inv);
      push(VEC[v][13:6]);
      rx_frame(VEC[v][13:6], 1'b1);
    end
    {c_eight, c_pe, c_odd, c_two, c_frc, c_inv} = 6'b100000;
    repeat (4) @(negedge clk);

    // R10 handshake and back-to-back characters
    push(8'h11);
    check(in_ready == 1'b0, "R10 ready drops after accept", in_ready, 0);
    fork
      push(8'h22);
      rx_frame(8'h11, 1'b0);
    join
    rx_frame(8'h22, 1'b1);

    // R8 flow control: held while cts_n high
    c_ign = 1'b0;
    cts_n = 1'b1;
    push(8'h6B);
    all_low = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (tx_line == 1'b0) all_low = 1'b1;
    end
    check(all_low == 1'b0, "R8 no start while cts_n high", all_low, 0);
    check(tx_done == 1'b0, "R9 done low with byte pending", tx_done, 0);
    cts_n = 1'b0;
    rx_frame(8'h6B, 1'b1);
    // R8 character in progress completes after cts_n rises
    push(8'hC3);
    fork
      rx_frame(8'hC3, 1'b1);
      begin repeat (200) @(negedge clk); cts_n = 1'b1; end
    join
    cts_n = 1'b0;
    c_ign = 1'b1;

    // R6 break requested mid-character waits for the boundary
    push(8'h96);
    fork
      rx_frame(8'h96, 1'b0);
      begin repeat (150) @(negedge clk); c_brk = 1'b1; end
    join
    repeat (2 * BITCLK) @(negedge clk);
    all_low = 1'b1;
    for (int i = 0; i < 8; i++) begin
      repeat (HALF) @(negedge clk);
      if (tx_line != 1'b0) all_low = 1'b0;
    end
    check(all_low == 1'b1, "R6 line low during break", all_low, 1);
    check(tx_done == 1'b0, "R9 done low during break", tx_done, 0);
    push(8'h4E);
    repeat (100) @(negedge clk);
    check(tx_line == 1'b0, "R6 pending byte waits for break release", tx_line, 0);
    c_brk = 1'b0;
    while (tx_line != 1'b1) @(negedge clk);
    hi_len = 0;
    while (tx_line != 1'b0) begin
      @(negedge clk);
      hi_len++;
    end
    check(hi_len >= 60 && hi_len <= 80, "R6 stop-length gap after break", hi_len, BITCLK);
    rx_body(8'h4E, 1'b1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule